// File: doc/BRIEF.md
# Carry-Save Multiplier Bit Step Chain

This block advances a signed shift-and-add multiplication by a fixed number of multiplier bits in one pass of combinational logic. The running partial product is held in redundant form, as two vectors (a sum vector and a carry vector) whose arithmetic total is the partial product. Each internal step looks at one multiplier bit. It either adds nothing or adds the multiplicand, or, when it handles the multiplier's sign bit, it subtracts the multiplicand. It then halves the result and releases the lowest bit as a finished product bit.

Within a step no carry travels sideways from one bit position to the next. Every column is an independent full adder, and its carry is passed to the following step in the chain. The depth of a step therefore does not grow with the operand width. The surrounding logic owns the registers, the iteration count and the final conversion of the two vectors to a plain binary number. It feeds the block's outputs back into its inputs until all multiplier bits are used.

A subtraction needs a +1 at the least significant position. The step where that happens is the last one of the whole multiplication, so this +1 leaves the chain as a separate one-bit correction term. The integrator adds it during the final conversion.

Top module: `csm_step_chain`

## Requirements
- R1: A multiplier bit of 0 contributes no addend. With all of `mbits` at 0, the output total equals the input total (`in_sum` + `in_carry`, both signed) shifted arithmetically right by STEPS, and `prod_bits` equals the STEPS low bits of the input total.
- R2: A multiplier bit of 1 on a step that is not flagged as the sign step adds the signed multiplicand to that step's partial product.
- R3: A multiplier bit of 1 on the flagged sign step subtracts the signed multiplicand from that step's partial product.
- R4: A multiplier bit of 0 on the flagged sign step adds zero, and `out_fix` stays 0.
- R5: Step k (k = 0 first) handles `mbits[k]`. With T = partial total + addend, `prod_bits[k]` is bit 0 of T and the total passed on is floor(T/2). The chain's output total is signed(`out_sum`) + signed(`out_carry`) + `out_fix`. All zero inputs give all zero outputs.
- R6: `last_is_sign` affects only the step that handles `mbits[STEPS-1]`. A set `mbits[0]` under `last_is_sign` = 1 still adds the multiplicand.
- R7: `out_fix` can be 1 only when `last_is_sign` = 1 and `mbits[STEPS-1]` = 1.
- R8: Starting from a zero partial product with `last_is_sign` = 1, (output total × 2^STEPS) + `prod_bits` equals the signed product of `mcand` and `mbits`, both read as two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_sum | input | MCAND_W+1 | Sum vector of the incoming partial product, two's complement |
| in_carry | input | MCAND_W+1 | Carry vector of the incoming partial product, two's complement, same weight as `in_sum` |
| mcand | input | MCAND_W | Signed multiplicand |
| mbits | input | STEPS | Multiplier bits for this pass, bit 0 handled first |
| last_is_sign | input | 1 | Marks `mbits[STEPS-1]` as the multiplier's sign bit |
| out_sum | output | MCAND_W+1 | Sum vector of the outgoing partial product |
| out_carry | output | MCAND_W+1 | Carry vector of the outgoing partial product |
| out_fix | output | 1 | Pending +1 (weight 1 in the outgoing total) left over from a subtraction |
| prod_bits | output | STEPS | Finished low-order product bits, bit k from step k |

## Verification
The hardest situation to reach is a subtraction that produces the leftover +1. This needs the sign step to see a set bit while the low sum bit of its adder row is also 1. That depends on the carry-save split of the incoming vectors and not only on their total. The stimulus therefore drives the sum and carry vectors independently with random patterns, and cycles the last multiplier bit and the sign flag through all four combinations. The product table adds the extreme operands: the most negative multiplicand times the most negative multiplier, and the largest positive operands.

// File: rtl/csm_pkg.sv
// Package: shared types and bit-level helpers for the carry-save step chain.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package csm_pkg;

    // What a single step adds to its partial product.
    typedef enum logic [1:0] {
        ADD_NONE  = 2'b00,
        ADD_PLUS  = 2'b01,
        ADD_MINUS = 2'b10
    } addend_kind_e;

    // Majority of three bits: the carry of a full adder.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Sum bit of a full adder.
    function automatic logic xor3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

endpackage

// File: rtl/csm_addend_sel.sv
// Module: csm_addend_sel
// Picks the addend of one step: zero, the sign-extended multiplicand, or its
// bitwise inverse together with a +1 injection for a subtraction.
// Assumes: W > MCAND_W, so sign extension never loses information.
module csm_addend_sel
    import csm_pkg::*;
#(
    parameter int MCAND_W = 12,
    parameter int W       = MCAND_W + 1
) (
    input  logic [MCAND_W-1:0] mcand,
    input  logic               mbit,
    input  logic               is_sign,
    output logic [W-1:0]       addend,
    output logic               inject
);
    localparam int EXT_W = W - MCAND_W;

    addend_kind_e        kind;
    logic [W-1:0]        mext;

    // Sign-extend the multiplicand to the adder width.
    assign mext = {{EXT_W{mcand[MCAND_W-1]}}, mcand};

    // Decide the kind of addend from the bit and the sign-step flag.
    always_comb begin
        if (!mbit)        kind = ADD_NONE;
        else if (is_sign) kind = ADD_MINUS;
        else              kind = ADD_PLUS;
    end

    // Form the addend vector and the least significant injection.
    always_comb begin
        unique case (kind)
            ADD_PLUS:  begin addend = mext;       inject = 1'b0; end
            ADD_MINUS: begin addend = ~mext;      inject = 1'b1; end
            default:   begin addend = '0;         inject = 1'b0; end
        endcase
    end

endmodule

// File: rtl/csm_csa_row.sv
// Module: csm_csa_row
// A row of independent full adders that compresses three W-bit vectors into
// a sum vector and a carry vector; no signal crosses between columns.
// Assumes: inputs are two's complement, so the top column acts as the sign column.
module csm_csa_row
    import csm_pkg::*;
#(
    parameter int W = 13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] cy
);
    // One full adder per column.
    for (genvar i = 0; i < W; i++) begin : g_col
        assign sum[i] = xor3(a[i], b[i], c[i]);
        assign cy[i]  = maj3(a[i], b[i], c[i]);
    end

endmodule

// File: rtl/csm_bit_step.sv
// Module: csm_bit_step
// Handles one multiplier bit: adds the selected addend to the carry-save
// partial product, releases bit 0 as a product bit and halves the rest.
// Assumes: the carry vector has the same weight as the sum vector; a +1
// injection only happens on the final (sign) step of a multiplication.
module csm_bit_step #(
    parameter int MCAND_W = 12,
    parameter int W       = MCAND_W + 1
) (
    input  logic [W-1:0]       ps_sum,
    input  logic [W-1:0]       ps_carry,
    input  logic [MCAND_W-1:0] mcand,
    input  logic               mbit,
    input  logic               is_sign,
    output logic [W-1:0]       nx_sum,
    output logic [W-1:0]       nx_carry,
    output logic               fix,
    output logic               pbit
);
    logic [W-1:0] addend;
    logic         inject;
    logic [W-1:0] row_sum;
    logic [W-1:0] row_cy;

    csm_addend_sel #(.MCAND_W(MCAND_W), .W(W)) u_sel (
        .mcand   (mcand),
        .mbit    (mbit),
        .is_sign (is_sign),
        .addend  (addend),
        .inject  (inject)
    );

    csm_csa_row #(.W(W)) u_row (
        .a   (ps_sum),
        .b   (ps_carry),
        .c   (addend),
        .sum (row_sum),
        .cy  (row_cy)
    );

    // Release bit 0 (sum bit plus injection) and halve: the sum vector shifts
    // arithmetically, while the carries already carry double weight.
    always_comb begin
        pbit     = row_sum[0] ^ inject;
        fix      = row_sum[0] & inject;
        nx_sum   = {row_sum[W-1], row_sum[W-1:1]};
        nx_carry = row_cy;
    end

endmodule

// File: rtl/csm_step_chain.sv
// Module: csm_step_chain (top)
// Chains STEPS bit steps so one pass consumes STEPS multiplier bits. Only the
// last step can be flagged as the sign step; its leftover +1 leaves as out_fix.
// Assumes: MCAND_W >= 2, STEPS >= 1; the caller adds out_fix at final conversion.
module csm_step_chain #(
    parameter int MCAND_W = 12,
    parameter int STEPS   = 4,
    parameter int W       = MCAND_W + 1
) (
    input  logic [W-1:0]       in_sum,
    input  logic [W-1:0]       in_carry,
    input  logic [MCAND_W-1:0] mcand,
    input  logic [STEPS-1:0]   mbits,
    input  logic               last_is_sign,
    output logic [W-1:0]       out_sum,
    output logic [W-1:0]       out_carry,
    output logic               out_fix,
    output logic [STEPS-1:0]   prod_bits
);
    logic [W-1:0]     sum_link   [STEPS+1];
    logic [W-1:0]     carry_link [STEPS+1];
    logic [STEPS-1:0] fix_vec;

    // Feed the chain from the ports.
    assign sum_link[0]   = in_sum;
    assign carry_link[0] = in_carry;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        localparam bit IS_LAST = (k == STEPS - 1);
        csm_bit_step #(.MCAND_W(MCAND_W), .W(W)) u_step (
            .ps_sum   (sum_link[k]),
            .ps_carry (carry_link[k]),
            .mcand    (mcand),
            .mbit     (mbits[k]),
            .is_sign  (IS_LAST ? last_is_sign : 1'b0),
            .nx_sum   (sum_link[k+1]),
            .nx_carry (carry_link[k+1]),
            .fix      (fix_vec[k]),
            .pbit     (prod_bits[k])
        );
    end

    // Drive the outgoing partial product; only the last step can raise a fix.
    always_comb begin
        out_sum   = sum_link[STEPS];
        out_carry = carry_link[STEPS];
        out_fix   = |fix_vec;
    end

endmodule

// File: rtl/csm_step_chain_chk.sv
// Module: csm_step_chain_chk
// Assertion checker bound to csm_step_chain; observes ports only.
// Assumes: MCAND_W + STEPS + 2 fits in 64 bits for the arithmetic reference.
module csm_step_chain_chk #(
    parameter int MCAND_W = 12,
    parameter int STEPS   = 4,
    parameter int W       = MCAND_W + 1
) (
    input logic [W-1:0]       in_sum,
    input logic [W-1:0]       in_carry,
    input logic [MCAND_W-1:0] mcand,
    input logic [STEPS-1:0]   mbits,
    input logic               last_is_sign,
    input logic [W-1:0]       out_sum,
    input logic [W-1:0]       out_carry,
    input logic               out_fix,
    input logic [STEPS-1:0]   prod_bits
);
    longint           a_in;
    longint           v_out;
    longint           v_ref;
    logic [STEPS-1:0] b_ref;

    // Arithmetic reference of the whole chain on plain integers.
    always_comb begin
        longint t;
        a_in  = longint'($signed(in_sum)) + longint'($signed(in_carry));
        v_out = longint'($signed(out_sum)) + longint'($signed(out_carry)) + longint'(out_fix);
        v_ref = a_in;
        b_ref = '0;
        for (int k = 0; k < STEPS; k++) begin
            t = v_ref;
            if (mbits[k])
                t = (last_is_sign && k == STEPS - 1) ? v_ref - longint'($signed(mcand))
                                                     : v_ref + longint'($signed(mcand));
            b_ref[k] = t[0];
            v_ref    = t >>> 1;
        end
    end

    // Immediate checks on the settled combinational outputs.
    always_comb begin
        // R5
        value_track_chk: assert (v_out == v_ref && prod_bits == b_ref)
            else $error("chain total or product bits differ from arithmetic");
        // R7
        fix_only_on_sub_chk: assert (!out_fix || (last_is_sign && mbits[STEPS-1]))
            else $error("out_fix raised without a subtraction");
        // R1
        if (mbits == '0) begin
            idle_shift_chk: assert (v_out == (a_in >>> STEPS) && prod_bits == STEPS'(a_in))
                else $error("zero multiplier bits did not plainly shift");
        end
        // R4
        if (last_is_sign && !mbits[STEPS-1]) begin
            sign_zero_chk: assert (!out_fix)
                else $error("sign bit 0 produced a correction");
        end
        // R8
        if (in_sum == '0 && in_carry == '0 && last_is_sign) begin
            full_product_chk: assert ((v_out * (longint'(1) << STEPS)) + longint'(prod_bits)
                                      == longint'($signed(mcand)) * longint'($signed(mbits)))
                else $error("signed product mismatch");
        end
    end

endmodule

bind csm_step_chain csm_step_chain_chk #(.MCAND_W(MCAND_W), .STEPS(STEPS), .W(W)) u_chk (.*);

// File: tb/csm_step_chain_bench.sv
module csm_step_chain_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 12;
    localparam int ST = 4;
    localparam int W  = MW + 1;
    localparam int NTV = 10;

    // Product table: multiplicand, multiplier (4-bit signed), expected product.
    localparam int TV_MCAND [NTV] = '{5, 5, -2048, 2047, -2048, 2047, 0, -1, 100, -7};
    localparam int TV_MULT  [NTV] = '{3, -1, -8, 7, 7, -8, -8, -1, -3, 5};
    localparam int TV_PROD  [NTV] = '{15, -5, 16384, 14329, -14336, -16376, 0, 1, -300, -35};

    logic clk = 1'b0;
    logic [W-1:0]  in_sum, in_carry, out_sum, out_carry;
    logic [MW-1:0] mcand;
    logic [ST-1:0] mbits, prod_bits;
    logic          last_is_sign, out_fix;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csm_step_chain #(.MCAND_W(MW), .STEPS(ST)) u_csm_step_chain (
        .in_sum(in_sum), .in_carry(in_carry), .mcand(mcand), .mbits(mbits),
        .last_is_sign(last_is_sign), .out_sum(out_sum), .out_carry(out_carry),
        .out_fix(out_fix), .prod_bits(prod_bits)
    );

    task automatic apply(input logic [W-1:0] s, input logic [W-1:0] c,
                         input logic [MW-1:0] m, input logic [ST-1:0] b, input logic sg);
        @(posedge clk);
        in_sum = s; in_carry = c; mcand = m; mbits = b; last_is_sign = sg;
        @(negedge clk);
    endtask

    function automatic longint total_out();
        return longint'($signed(out_sum)) + longint'($signed(out_carry)) + longint'(out_fix);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Independent model: one multiplier bit at a time on integers.
    task automatic model(input longint a0, input longint m, input logic [ST-1:0] b,
                         input logic sg, output longint a, output logic [ST-1:0] bits);
        longint t;
        a = a0;
        bits = '0;
        for (int k = 0; k < ST; k++) begin
            t = a;
            if (b[k]) t = (sg && k == ST-1) ? a - m : a + m;
            bits[k] = t[0];
            a = t >>> 1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        longint exp_v, got;
        logic [ST-1:0] exp_b;
        in_sum = '0; in_carry = '0; mcand = '0; mbits = '0; last_is_sign = 1'b0;

        // R5: all zero in, all zero out
        apply('0, '0, '0, '0, 1'b0);
        check(out_sum == '0 && out_carry == '0 && !out_fix && prod_bits == '0,
              "R5 zero state", total_out(), 0);

        // R8: signed product table
        for (int i = 0; i < NTV; i++) begin
            apply('0, '0, MW'(TV_MCAND[i]), ST'(TV_MULT[i]), 1'b1);
            got = total_out() * 16 + longint'(prod_bits);
            check(got == longint'(TV_PROD[i]), "R8 product", got, longint'(TV_PROD[i]));
        end

        // R2: top bit as ordinary bit adds
        apply('0, '0, MW'(1234), 4'b1000, 1'b0);
        got = total_out() * 16 + longint'(prod_bits);
        check(got == 9872, "R2 add on non-sign step", got, 9872);
        // R3: top bit as sign bit subtracts
        apply('0, '0, MW'(1234), 4'b1000, 1'b1);
        got = total_out() * 16 + longint'(prod_bits);
        check(got == -9872, "R3 subtract on sign step", got, -9872);
        // R4: sign bit 0 adds zero
        apply('0, '0, MW'(100), 4'b0111, 1'b1);
        got = total_out() * 16 + longint'(prod_bits);
        check(got == 700 && !out_fix, "R4 sign bit zero", got, 700);
        // R6: flag leaves bit 0 alone
        apply('0, '0, MW'(-300), 4'b0001, 1'b1);
        got = total_out() * 16 + longint'(prod_bits);
        check(got == -300, "R6 flag only on last step", got, -300);

        // R1: zero multiplier bits only shift the incoming total
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] s, c;
            s = W'($urandom); c = W'($urandom);
            apply(s, c, MW'($urandom), '0, i[0]);
            exp_v = longint'($signed(s)) + longint'($signed(c));
            check(total_out() == (exp_v >>> ST) && prod_bits == ST'(exp_v),
                  "R1 idle shift", total_out(), exp_v >>> ST);
        end

        // R5 R7: random split vectors over all four top-bit/flag combinations
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0]  s, c;
            logic [MW-1:0] m;
            logic [ST-1:0] b;
            s = W'($urandom); c = W'($urandom); m = MW'($urandom); b = ST'($urandom);
            b[ST-1] = i[0];
            apply(s, c, m, b, i[1]);
            model(longint'($signed(s)) + longint'($signed(c)), longint'($signed(m)),
                  b, i[1], exp_v, exp_b);
            check(total_out() == exp_v, "R5 total", total_out(), exp_v);
            check(prod_bits == exp_b, "R5 product bits", longint'(prod_bits), longint'(exp_b));
            check(!out_fix || (i[1] && i[0]), "R7 fix source", longint'(out_fix), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule